// File: doc/BRIEF.md
# Synchronous Dual-Port Burst RAM

This block is a two-port synchronous memory. A left and a right port each run on their own clock and reach one shared array. Each port has a burst address counter, two chip enables, a read/write select, an output enable and two byte-lane selects. A per-port mode pin picks how quickly read data appears.

The counter lets a host issue one address and then stream consecutive words without driving the address again. Each port has three counter controls: clear, load and step. The address used for an access is always the value the counter takes at that clock edge. A load therefore accesses the supplied address, and each step accesses the next word. Read data reaches the port either straight after the edge that performs the read, or one edge later through an extra register. The high-impedance state of a byte lane is reported as a per-lane drive flag, with the data of that lane forced to zero.

The default build has 1024 words of 18 bits. Setting `ADDR_W` to 13 gives 8K words with 13 address bits per port. Each word is split into two lanes: the lower half is bits [LANE_W-1:0] and the upper half is bits [DATA_W-1:LANE_W].

Top module: `burst_dpram`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits that both ports share. The lower lane is bits [DATA_W/2-1:0] and is gated by `*_lo_n`. The upper lane is bits [DATA_W-1:DATA_W/2] and is gated by `*_hi_n`.
- R2: When `*_clr_n` is 0, the access address of that cycle is 0 and the counter becomes 0, whatever `*_load_n` and `*_step_n` are.
- R3: When `*_clr_n` is 1 and `*_load_n` is 0, the access address is `*_addr` and the counter takes it. `*_step_n` has no effect in that cycle.
- R4: When only `*_step_n` is 0, the access address is the counter plus one modulo 2**ADDR_W, so the last word wraps to 0, and the counter takes that value. With all three controls at 1, the access address is the counter and the counter holds.
- R5: A port is selected only while `*_cs0_n` is 0 and `*_cs1` is 1. An unselected port neither reads nor writes, but its counter still follows R2 to R4.
- R6: A selected port with `*_rnw` at 0 writes `*_wdata` into the lanes whose select is 0. Lanes whose select is 1 keep their contents.
- R7: A selected port with `*_rnw` at 1 reads. Bit k of `*_drive` (k=0 lower, k=1 upper) is 1 only while `*_oe_n` is 0 and lane k's select was 0 at the read. The data bits of an undriven lane read as 0.
- R8: With `*_pipe` at 0, the data of a read made at an edge is presented from that edge until the next one.
- R9: With `*_pipe` at 1, the data of a read made at an edge is presented one edge later, for one cycle.
- R10: A read of a word that either port writes at the same edge returns the contents from before that edge.
- R11: With a shared clock, when both ports write the same lane of the same word at the same edge, the left port's data is stored. Writes to different lanes of that word both take effect.
- R12: Each port's `*_rst_n` at 0 clears that port's counter and read stages at once, so `*_drive` is 0. Array contents are kept.
- R13: Data written through one port is read back unchanged through the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| l_clk | input | 1 | Left port clock |
| l_rst_n | input | 1 | Left asynchronous reset, active low |
| l_addr | input | ADDR_W | Left external address |
| l_load_n | input | 1 | Left counter load / address strobe, active low |
| l_step_n | input | 1 | Left counter step, active low |
| l_clr_n | input | 1 | Left counter clear, active low |
| l_cs0_n | input | 1 | Left chip enable, active low |
| l_cs1 | input | 1 | Left chip enable, active high |
| l_rnw | input | 1 | Left read (1) / write (0) |
| l_lo_n | input | 1 | Left lower-lane select, active low |
| l_hi_n | input | 1 | Left upper-lane select, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_pipe | input | 1 | Left read mode: 0 flow-through, 1 pipelined |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, 0 on undriven lanes |
| l_drive | output | 2 | Left per-lane drive flags |
| r_clk | input | 1 | Right port clock |
| r_rst_n | input | 1 | Right asynchronous reset, active low |
| r_addr | input | ADDR_W | Right external address |
| r_load_n | input | 1 | Right counter load / address strobe, active low |
| r_step_n | input | 1 | Right counter step, active low |
| r_clr_n | input | 1 | Right counter clear, active low |
| r_cs0_n | input | 1 | Right chip enable, active low |
| r_cs1 | input | 1 | Right chip enable, active high |
| r_rnw | input | 1 | Right read (1) / write (0) |
| r_lo_n | input | 1 | Right lower-lane select, active low |
| r_hi_n | input | 1 | Right upper-lane select, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_pipe | input | 1 | Right read mode: 0 flow-through, 1 pipelined |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, 0 on undriven lanes |
| r_drive | output | 2 | Right per-lane drive flags |

## Verification
The bench builds the block with ADDR_W=6 and DATA_W=18, a 64-word array. A single burst then runs the counter through the wrap from word 63 to word 0, and random addresses from both ports land on the same word often enough to exercise same-edge collisions and read-before-write. Both ports share one clock in the bench, which is the only case in which the left-wins collision rule is defined.

// File: rtl/burst_dpram_pkg.sv
package burst_dpram_pkg;

  localparam int NUM_LANES = 2;

  // Source of the access address in one cycle, highest priority first.
  typedef enum logic [1:0] {
    SRC_CLEAR = 2'd3,
    SRC_LOAD  = 2'd2,
    SRC_STEP  = 2'd1,
    SRC_HOLD  = 2'd0
  } acc_src_e;

  function automatic acc_src_e pick_src(input logic clr_n, input logic load_n,
                                        input logic step_n);
    if (!clr_n)       return SRC_CLEAR;
    else if (!load_n) return SRC_LOAD;
    else if (!step_n) return SRC_STEP;
    else              return SRC_HOLD;
  endfunction

  function automatic logic port_selected(input logic cs0_n, input logic cs1);
    return !cs0_n && cs1;
  endfunction

  function automatic logic [NUM_LANES-1:0] lane_request(input logic lo_n,
                                                        input logic hi_n);
    return {~hi_n, ~lo_n};
  endfunction

  function automatic logic [NUM_LANES-1:0] write_lanes(input logic sel,
                                                       input logic rnw,
                                                       input logic [NUM_LANES-1:0] req);
    return (sel && !rnw) ? req : '0;
  endfunction

endpackage

// File: rtl/burst_ctr.sv
module burst_ctr
  import burst_dpram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              clr_n,
  input  logic              load_n,
  input  logic              step_n,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] cnt_q
);

  acc_src_e src;

  assign src = pick_src(clr_n, load_n, step_n);

  // The access address is the value the counter takes at this edge.
  always_comb begin
    case (src)
      SRC_CLEAR: acc_addr = '0;
      SRC_LOAD:  acc_addr = ext_addr;
      SRC_STEP:  acc_addr = cnt_q + 1'b1;
      default:   acc_addr = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= acc_addr;
  end

endmodule

// File: rtl/lane_bank.sv
module lane_bank #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9
) (
  input  logic              clk_l,
  input  logic              we_l,
  input  logic [ADDR_W-1:0] a_l,
  input  logic [LANE_W-1:0] d_l,
  output logic [LANE_W-1:0] q_l,
  input  logic              clk_r,
  input  logic              we_r,
  input  logic [ADDR_W-1:0] a_r,
  input  logic [LANE_W-1:0] d_r,
  output logic [LANE_W-1:0] q_r
);

  localparam int DEPTH = 1 << ADDR_W;

  // Each port owns one half; a word's value is the XOR of both halves.
  logic [LANE_W-1:0] half_l [DEPTH];
  logic [LANE_W-1:0] half_r [DEPTH];

  always_ff @(posedge clk_l) begin
    if (we_l) half_l[a_l] <= d_l ^ half_r[a_l];
  end

  always_ff @(posedge clk_r) begin
    if (we_r) half_r[a_r] <= d_r ^ half_l[a_r];
  end

  assign q_l = half_l[a_l] ^ half_r[a_l];
  assign q_r = half_l[a_r] ^ half_r[a_r];

endmodule

// File: rtl/burst_rd_path.sv
module burst_rd_path #(
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_go,
  input  logic [LANES-1:0]         lane_req,
  input  logic [LANES*LANE_W-1:0]  mem_q,
  input  logic                     pipe,
  input  logic                     oe_n,
  output logic [LANES*LANE_W-1:0]  rdata,
  output logic [LANES-1:0]         drive
);

  localparam int DW = LANES * LANE_W;

  logic [DW-1:0]    s1_d, s2_d, out_d;
  logic [LANES-1:0] s1_f, s2_f, out_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_d <= '0;
      s1_f <= '0;
      s2_d <= '0;
      s2_f <= '0;
    end else begin
      s2_d <= s1_d;
      s2_f <= s1_f;
      s1_f <= rd_go ? lane_req : '0;
      if (rd_go) s1_d <= mem_q;
    end
  end

  assign out_d = pipe ? s2_d : s1_d;
  assign out_f = pipe ? s2_f : s1_f;
  assign drive = out_f & {LANES{~oe_n}};

  for (genvar g = 0; g < LANES; g++) begin : g_gate
    assign rdata[g*LANE_W +: LANE_W] = drive[g] ? out_d[g*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/burst_dpram.sv
module burst_dpram
  import burst_dpram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              l_clk,
  input  logic              l_rst_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_load_n,
  input  logic              l_step_n,
  input  logic              l_clr_n,
  input  logic              l_cs0_n,
  input  logic              l_cs1,
  input  logic              l_rnw,
  input  logic              l_lo_n,
  input  logic              l_hi_n,
  input  logic              l_oe_n,
  input  logic              l_pipe,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic [1:0]        l_drive,
  input  logic              r_clk,
  input  logic              r_rst_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_load_n,
  input  logic              r_step_n,
  input  logic              r_clr_n,
  input  logic              r_cs0_n,
  input  logic              r_cs1,
  input  logic              r_rnw,
  input  logic              r_lo_n,
  input  logic              r_hi_n,
  input  logic              r_oe_n,
  input  logic              r_pipe,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic [1:0]        r_drive
);

  localparam int LANES  = NUM_LANES;
  localparam int LANE_W = DATA_W / LANES;

  // Named internal events
  logic [ADDR_W-1:0] l_acc, l_cnt, r_acc, r_cnt;
  logic              l_sel, l_rd_go, r_sel, r_rd_go;
  logic [LANES-1:0]  l_lane_req, l_wr_lane, r_lane_req, r_wr_req, r_wr_lane;
  logic [LANES-1:0]  clash;
  logic              same_word;
  logic [DATA_W-1:0] l_mem_q, r_mem_q;

  burst_ctr #(.ADDR_W(ADDR_W)) u_l_ctr (
    .clk(l_clk), .rst_n(l_rst_n), .ext_addr(l_addr), .clr_n(l_clr_n),
    .load_n(l_load_n), .step_n(l_step_n), .acc_addr(l_acc), .cnt_q(l_cnt)
  );

  burst_ctr #(.ADDR_W(ADDR_W)) u_r_ctr (
    .clk(r_clk), .rst_n(r_rst_n), .ext_addr(r_addr), .clr_n(r_clr_n),
    .load_n(r_load_n), .step_n(r_step_n), .acc_addr(r_acc), .cnt_q(r_cnt)
  );

  assign l_sel      = port_selected(l_cs0_n, l_cs1);
  assign r_sel      = port_selected(r_cs0_n, r_cs1);
  assign l_lane_req = lane_request(l_lo_n, l_hi_n);
  assign r_lane_req = lane_request(r_lo_n, r_hi_n);
  assign l_rd_go    = l_sel & l_rnw;
  assign r_rd_go    = r_sel & r_rnw;
  assign l_wr_lane  = write_lanes(l_sel, l_rnw, l_lane_req);
  assign r_wr_req   = write_lanes(r_sel, r_rnw, r_lane_req);

  // Same word, same lane, same edge: the left port keeps the lane.
  assign same_word = (l_acc == r_acc);
  assign clash     = l_wr_lane & r_wr_req & {LANES{same_word}};
  assign r_wr_lane = r_wr_req & ~clash;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
      .clk_l(l_clk), .we_l(l_wr_lane[k]), .a_l(l_acc),
      .d_l(l_wdata[k*LANE_W +: LANE_W]), .q_l(l_mem_q[k*LANE_W +: LANE_W]),
      .clk_r(r_clk), .we_r(r_wr_lane[k]), .a_r(r_acc),
      .d_r(r_wdata[k*LANE_W +: LANE_W]), .q_r(r_mem_q[k*LANE_W +: LANE_W])
    );
  end

  burst_rd_path #(.LANE_W(LANE_W), .LANES(LANES)) u_l_rd (
    .clk(l_clk), .rst_n(l_rst_n), .rd_go(l_rd_go), .lane_req(l_lane_req),
    .mem_q(l_mem_q), .pipe(l_pipe), .oe_n(l_oe_n), .rdata(l_rdata), .drive(l_drive)
  );

  burst_rd_path #(.LANE_W(LANE_W), .LANES(LANES)) u_r_rd (
    .clk(r_clk), .rst_n(r_rst_n), .rd_go(r_rd_go), .lane_req(r_lane_req),
    .mem_q(r_mem_q), .pipe(r_pipe), .oe_n(r_oe_n), .rdata(r_rdata), .drive(r_drive)
  );

endmodule

// File: rtl/burst_dpram_chk.sv
module burst_dpram_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input logic              l_clk,
  input logic              l_rst_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_load_n,
  input logic              l_step_n,
  input logic              l_clr_n,
  input logic              l_lo_n,
  input logic              l_oe_n,
  input logic              l_pipe,
  input logic [DATA_W-1:0] l_rdata,
  input logic [1:0]        l_drive,
  input logic [ADDR_W-1:0] l_cnt,
  input logic              l_rd_go,
  input logic              r_clk,
  input logic              r_rst_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_load_n,
  input logic              r_clr_n,
  input logic [ADDR_W-1:0] r_cnt
);

  // R2
  l_clear_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
    !l_clr_n |=> (l_cnt == '0));

  // R2
  r_clear_chk: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    !r_clr_n |=> (r_cnt == '0));

  // R3
  l_load_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
    (l_clr_n && !l_load_n) |=> (l_cnt == $past(l_addr)));

  // R3
  r_load_chk: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    (r_clr_n && !r_load_n) |=> (r_cnt == $past(r_addr)));

  // R4
  l_step_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
    (l_clr_n && l_load_n && !l_step_n) |=> (l_cnt == ADDR_W'($past(l_cnt) + 1'b1)));

  // R4
  l_hold_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
    (l_clr_n && l_load_n && l_step_n) |=> $stable(l_cnt));

  // R7
  l_oe_quiet_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
    l_oe_n |-> (l_drive == 2'b00));

  // R7
  l_noread_quiet_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
    (!$past(l_rd_go) && !$past(l_rd_go, 2)) |-> (l_drive == 2'b00));

  // R7
  l_zero_data_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
    (l_drive == 2'b00) |-> (l_rdata == '0));

  // R8
  l_flow_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
    ($past(l_rst_n) && !l_pipe && $past(l_rd_go) && !$past(l_lo_n) && !l_oe_n)
      |-> l_drive[0]);

  // R9
  l_pipe_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
    ($past(l_rst_n, 2) && $past(l_rst_n) && l_pipe && $past(l_rd_go, 2) &&
     !$past(l_lo_n, 2) && !l_oe_n) |-> l_drive[0]);

  // R12
  always @(posedge l_clk) begin
    if (!l_rst_n) begin
      l_reset_quiet_chk: assert (l_drive == 2'b00);
    end
  end

endmodule

bind burst_dpram burst_dpram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .l_clk(l_clk), .l_rst_n(l_rst_n), .l_addr(l_addr), .l_load_n(l_load_n),
  .l_step_n(l_step_n), .l_clr_n(l_clr_n), .l_lo_n(l_lo_n), .l_oe_n(l_oe_n),
  .l_pipe(l_pipe), .l_rdata(l_rdata), .l_drive(l_drive), .l_cnt(l_cnt),
  .l_rd_go(l_rd_go), .r_clk(r_clk), .r_rst_n(r_rst_n), .r_addr(r_addr),
  .r_load_n(r_load_n), .r_clr_n(r_clr_n), .r_cnt(r_cnt)
);

// File: tb/burst_dpram_bench.sv
module burst_dpram_bench;

  localparam int AW    = 6;
  localparam int DW    = 18;
  localparam int LW    = DW / 2;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic          clr_n, load_n, step_n, cs0_n, cs1, rnw, lo_n, hi_n, oe_n, pipe;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
  } pin_t;

  logic clk = 0;
  logic rst_n = 0;
  pin_t pi [2];
  pin_t nxt [2];
  logic [DW-1:0] rd_o [2];
  logic [1:0]    dv_o [2];

  int n_chk = 0;
  int n_bad = 0;
  string focus = "R12";
  logic rst_want = 0;
  logic ok_done = 0;

  // model state
  logic [DW-1:0] mem_m [DEPTH];
  logic [AW-1:0] cnt_m [2];
  logic [DW-1:0] s1d [2], s2d [2];
  logic [1:0]    s1f [2], s2f [2];

  always #10 clk = ~clk;

  burst_dpram #(.ADDR_W(AW), .DATA_W(DW)) u_burst_dpram (
    .l_clk(clk), .l_rst_n(rst_n), .l_addr(pi[0].addr), .l_load_n(pi[0].load_n),
    .l_step_n(pi[0].step_n), .l_clr_n(pi[0].clr_n), .l_cs0_n(pi[0].cs0_n),
    .l_cs1(pi[0].cs1), .l_rnw(pi[0].rnw), .l_lo_n(pi[0].lo_n), .l_hi_n(pi[0].hi_n),
    .l_oe_n(pi[0].oe_n), .l_pipe(pi[0].pipe), .l_wdata(pi[0].wdata),
    .l_rdata(rd_o[0]), .l_drive(dv_o[0]),
    .r_clk(clk), .r_rst_n(rst_n), .r_addr(pi[1].addr), .r_load_n(pi[1].load_n),
    .r_step_n(pi[1].step_n), .r_clr_n(pi[1].clr_n), .r_cs0_n(pi[1].cs0_n),
    .r_cs1(pi[1].cs1), .r_rnw(pi[1].rnw), .r_lo_n(pi[1].lo_n), .r_hi_n(pi[1].hi_n),
    .r_oe_n(pi[1].oe_n), .r_pipe(pi[1].pipe), .r_wdata(pi[1].wdata),
    .r_rdata(rd_o[1]), .r_drive(dv_o[1])
  );

  function automatic pin_t idle(input logic pipe);
    pin_t v;
    v = '0;
    v.clr_n = 1; v.load_n = 1; v.step_n = 1; v.cs0_n = 1; v.cs1 = 0;
    v.rnw = 1; v.lo_n = 1; v.hi_n = 1; v.oe_n = 1; v.pipe = pipe;
    return v;
  endfunction

  function automatic pin_t acc(input logic rnw, input logic load_n, input logic step_n,
                               input logic [AW-1:0] a, input logic [DW-1:0] d,
                               input logic pipe);
    pin_t v;
    v = idle(pipe);
    v.cs0_n = 0; v.cs1 = 1; v.rnw = rnw; v.lo_n = 0; v.hi_n = 0; v.oe_n = 0;
    v.load_n = load_n; v.step_n = step_n; v.addr = a; v.wdata = d;
    return v;
  endfunction

  function automatic logic [DW-1:0] widen(input logic [1:0] lanes);
    return {{LW{lanes[1]}}, {LW{lanes[0]}}};
  endfunction

  // Priority: clear, then load, then step, else hold; wraps modulo DEPTH.
  function automatic logic [AW-1:0] want_addr(input pin_t v, input logic [AW-1:0] c);
    if (!v.clr_n)  return '0;
    if (!v.load_n) return v.addr;
    if (!v.step_n) return AW'((32'(c) + 1) % DEPTH);
    return c;
  endfunction

  task automatic model_reset();
    for (int p = 0; p < 2; p++) begin
      cnt_m[p] = '0; s1d[p] = '0; s2d[p] = '0; s1f[p] = '0; s2f[p] = '0;
    end
  endtask

  task automatic model_edge();
    logic [AW-1:0] a [2];
    logic          sel [2];
    for (int p = 0; p < 2; p++) begin
      a[p]   = want_addr(pi[p], cnt_m[p]);
      sel[p] = !pi[p].cs0_n && pi[p].cs1;
      s2d[p] = s1d[p];
      s2f[p] = s1f[p];
      if (sel[p] && pi[p].rnw) begin
        s1d[p] = mem_m[a[p]];
        s1f[p] = {~pi[p].hi_n, ~pi[p].lo_n};
      end else begin
        s1f[p] = 2'b00;
      end
      cnt_m[p] = a[p];
    end
    // right first, left last: left wins any lane both touch
    for (int p = 1; p >= 0; p--) begin
      if (sel[p] && !pi[p].rnw) begin
        logic [DW-1:0] m;
        m = widen({~pi[p].hi_n, ~pi[p].lo_n});
        mem_m[a[p]] = (mem_m[a[p]] & ~m) | (pi[p].wdata & m);
      end
    end
  endtask

  task automatic check_out();
    for (int p = 0; p < 2; p++) begin
      logic [1:0]    f;
      logic [DW-1:0] d;
      f = (pi[p].pipe ? s2f[p] : s1f[p]) & {2{~pi[p].oe_n}};
      d = (pi[p].pipe ? s2d[p] : s1d[p]) & widen(f);
      n_chk++;
      if ({dv_o[p], rd_o[p]} !== {f, d}) begin
        n_bad++;
        $display("FAIL %s R7 %s port%0d: drive=%b data=%h expected drive=%b data=%h",
                 focus, pi[p].pipe ? "R9" : "R8", p, dv_o[p], rd_o[p], f, d);
      end
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    check_out();
    pi[0] = nxt[0];
    pi[1] = nxt[1];
    rst_n = rst_want;
    if (!rst_want) model_reset();
    else           model_edge();
    @(posedge clk);
  endtask

  task automatic both_idle(input int n);
    for (int i = 0; i < n; i++) begin
      nxt[0] = idle(nxt[0].pipe);
      nxt[1] = idle(nxt[1].pipe);
      cycle();
    end
  endtask

  function automatic pin_t rnd_pin(input logic pipe);
    pin_t v;
    v.clr_n  = ($urandom % 16) != 0;
    v.load_n = ($urandom % 4) != 0;
    v.step_n = ($urandom % 2) != 0;
    v.cs0_n  = ($urandom % 8) == 0;
    v.cs1    = ($urandom % 8) != 0;
    v.rnw    = ($urandom % 2) != 0;
    v.lo_n   = ($urandom % 4) == 0;
    v.hi_n   = ($urandom % 4) == 0;
    v.oe_n   = ($urandom % 6) == 0;
    v.pipe   = pipe;
    v.addr   = AW'($urandom);
    v.wdata  = DW'($urandom);
    return v;
  endfunction

  initial begin
    void'($urandom(32'h1234_5eed));
    model_reset();
    pi[0] = idle(0); pi[1] = idle(0);
    nxt[0] = idle(0); nxt[1] = idle(0);

    // R12: reset state
    focus = "R12";
    rst_want = 0;
    both_idle(3);
    rst_want = 1;
    both_idle(1);

    // R1 R4: fill every word by a left burst
    focus = "R1 R4";
    nxt[0] = acc(0, 0, 1, 0, DW'($urandom), 0);
    cycle();
    for (int i = 1; i < DEPTH; i++) begin
      nxt[0] = acc(0, 1, 0, 0, DW'($urandom), 0);
      cycle();
    end
    nxt[0] = idle(0);

    // R13: right reads back all words in a burst
    focus = "R13";
    nxt[1] = acc(1, 0, 1, 0, 0, 0);
    cycle();
    for (int i = 1; i < DEPTH; i++) begin
      nxt[1] = acc(1, 1, 0, 0, 0, 0);
      cycle();
    end
    both_idle(2);

    // R9: pipelined burst read
    focus = "R9";
    nxt[1] = acc(1, 0, 1, 10, 0, 1);
    cycle();
    for (int i = 0; i < 3; i++) begin
      nxt[1] = acc(1, 1, 0, 0, 0, 1);
      cycle();
    end
    nxt[1] = idle(1);
    nxt[1].oe_n = 0;
    cycle();
    both_idle(1);
    nxt[1] = idle(0);
    both_idle(1);

    // R4: wrap from last word to 0, then hold
    focus = "R4";
    nxt[1] = acc(1, 0, 1, AW'(DEPTH - 2), 0, 0); cycle();
    nxt[1] = acc(1, 1, 0, 0, 0, 0); cycle();
    nxt[1] = acc(1, 1, 0, 0, 0, 0); cycle();
    nxt[1] = acc(1, 1, 1, 0, 0, 0); cycle();

    // R2: clear beats load and step
    focus = "R2";
    nxt[1] = acc(1, 0, 0, 33, 0, 0);
    nxt[1].clr_n = 0;
    cycle();
    nxt[1] = acc(1, 1, 0, 0, 0, 0); cycle();

    // R3: load beats step
    focus = "R3";
    nxt[1] = acc(1, 0, 0, 20, 0, 0); cycle();
    nxt[1] = acc(1, 1, 0, 0, 0, 0); cycle();

    // R5: unselected writes are dropped
    focus = "R5";
    nxt[1] = idle(0);
    nxt[0] = acc(0, 0, 1, 40, 18'h2aaaa, 0); nxt[0].cs1 = 0; cycle();
    nxt[0] = acc(0, 0, 1, 40, 18'h15555, 0); nxt[0].cs0_n = 1; cycle();
    nxt[0] = idle(0);
    nxt[1] = acc(1, 0, 1, 40, 0, 0); cycle();

    // R6: lower-lane only write
    focus = "R6";
    nxt[1] = idle(0);
    nxt[0] = acc(0, 0, 1, 41, 18'h3ffff, 0); nxt[0].hi_n = 1; cycle();
    nxt[0] = idle(0);
    nxt[1] = acc(1, 0, 1, 41, 0, 0); cycle();

    // R7: output enable and lane gating on reads
    focus = "R7";
    nxt[1] = acc(1, 0, 1, 41, 0, 0); nxt[1].oe_n = 1; cycle();
    nxt[1] = acc(1, 0, 1, 41, 0, 0); nxt[1].lo_n = 1; cycle();
    nxt[1] = acc(1, 0, 1, 41, 0, 0); nxt[1].hi_n = 1; cycle();

    // R10: read of a word written at the same edge returns old data
    focus = "R10";
    nxt[0] = acc(0, 0, 1, 42, 18'h0f0f0, 0);
    nxt[1] = acc(1, 0, 1, 42, 0, 0); cycle();
    nxt[0] = idle(0);
    nxt[1] = acc(1, 0, 1, 42, 0, 0); cycle();

    // R11: same-word collisions
    focus = "R11";
    nxt[0] = acc(0, 0, 1, 43, 18'h11111, 0);
    nxt[1] = acc(0, 0, 1, 43, 18'h22222, 0); cycle();
    nxt[0] = acc(0, 0, 1, 44, 18'h0abcd, 0); nxt[0].hi_n = 1;
    nxt[1] = acc(0, 0, 1, 44, 18'h35432, 0); nxt[1].lo_n = 1; cycle();
    nxt[0] = idle(0);
    nxt[1] = acc(1, 0, 1, 43, 0, 0); cycle();
    nxt[1] = acc(1, 0, 1, 44, 0, 0); cycle();

    // R12: mid-run reset clears counters, contents kept
    focus = "R12";
    nxt[0] = acc(1, 0, 1, 50, 0, 0);
    nxt[1] = acc(1, 0, 1, 51, 0, 0); cycle();
    rst_want = 0;
    both_idle(2);
    rst_want = 1;
    nxt[0] = acc(1, 1, 1, 0, 0, 0);
    nxt[1] = acc(1, 1, 1, 0, 0, 0); cycle();
    both_idle(1);

    // R8 R9: random mixed traffic
    for (int seg = 0; seg < 12; seg++) begin
      logic lp, rp;
      lp = ($urandom % 2) != 0;
      rp = ($urandom % 2) != 0;
      focus = "R8 R10 R11";
      for (int i = 0; i < 250; i++) begin
        nxt[0] = rnd_pin(lp);
        nxt[1] = rnd_pin(rp);
        cycle();
      end
    end
    both_idle(3);

    ok_done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ok_done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule